// File: doc/BRIEF.md
# Byte-Wide Slave Bridge to a Shared Register Bank

This block is the slave end of a point-to-point, clock-synchronous request/response link. A master opens a transfer by presenting a command, a start address and a beat count in one request phase. The slave then moves that many byte-wide data beats. Beat i addresses the start address plus i. Every beat returns its own response: the slave reports either data valid or error, and the response holds until the master takes it. All signals are sampled on the rising clock edge.

Behind the link sits a bank of sixteen byte registers that a peripheral core also uses. The peripheral writes status and received bytes into the bank through its own write port, and reads control bytes through a combinational read port. The master learns that something arrived by polling the bank with read bursts. The upper four registers hold status, so the bus may read them but not write them. If the bus and the peripheral write the same register in the same cycle, the bus write is kept.

Top module: `bus_reg_bridge`

## Requirements
- R1: After reset, s_resp is NULL (00), s_rdata is 0 and every bank register reads 0 on the peripheral read port.
- R2: Commands are encoded IDLE=000, WR=001, RD=010. s_cmd_accept rises only for WR or RD while no burst is active. Any other code is ignored: it is not accepted and gives no response.
- R3: An accepted request carries the start address and m_burst_len beats, where a value of 0 means one beat. Beat i uses address start+i.
- R4: A write beat is taken at a rising edge where m_data_valid and s_data_accept are both high. On a legal beat the register holds m_wdata from that edge on.
- R5: Response codes are NULL=00, DVA=01 and ERR=11. Exactly one DVA or ERR response appears in the cycle after each beat is taken.
- R6: A DVA read response carries the register contents at the edge the beat was taken. s_rdata is 0 whenever s_resp is not DVA.
- R7: A beat addressed at 16 or above returns ERR, for reads and for writes, and changes no register.
- R8: Registers 12 to 15 are read-only from the bus. A bus write to them returns ERR and leaves the value unchanged. Bus reads of them return DVA.
- R9: A response and its data stay stable until m_resp_accept is high at a rising edge. No new beat is taken while an unaccepted response is held.
- R10: The peripheral write port can update any register, read-only ones included. p_rd_data shows the register selected by p_rd_addr without delay, and bus reads return the values the peripheral wrote.
- R11: If a bus write beat and a peripheral write hit the same register at the same edge, the register takes the bus data. If they hit different registers, both writes land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_cmd | input | 3 | Request command from the master |
| m_addr | input | 8 | Start address of the burst |
| m_burst_len | input | 4 | Beat count (0 is treated as 1) |
| m_data_valid | input | 1 | Master offers a write beat |
| m_wdata | input | 8 | Write beat data |
| s_cmd_accept | output | 1 | Request phase taken at this edge |
| s_data_accept | output | 1 | Write beat can be taken at this edge |
| s_resp | output | 2 | Response code of the oldest unaccepted beat |
| s_rdata | output | 8 | Read data accompanying a DVA read response |
| m_resp_accept | input | 1 | Master takes the response at this edge |
| p_wr_en | input | 1 | Peripheral register write strobe |
| p_wr_addr | input | 4 | Peripheral write register index |
| p_wr_data | input | 8 | Peripheral write data |
| p_rd_addr | input | 4 | Peripheral read register index |
| p_rd_data | output | 8 | Register contents at p_rd_addr |

## Verification
Two events can meet at one clock edge: a bus write beat being taken and a peripheral write strobe. The bench raises p_wr_en in the same cycle as it presents a write beat, with s_data_accept already high. It does this once aimed at the same register and once at a neighbouring register. Afterwards it reads the peripheral port: the shared register must hold the bus byte, and the neighbour must hold the peripheral byte. A second overlap happens when a held response is accepted at the same edge as the next beat is taken. The bench covers this with back-to-back burst beats and with a period of withheld accept, and judges it by the order and the count of the responses it logs.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'b000,
    CMD_WR   = 3'b001,
    CMD_RD   = 3'b010
  } cmd_e;

  typedef enum logic [1:0] {
    RSP_NULL = 2'b00,
    RSP_DVA  = 2'b01,
    RSP_ERR  = 2'b11
  } resp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR,
    ST_RD
  } phase_e;

  // number of beats a request asks for; a zero count still moves one beat
  function automatic int unsigned beat_count(int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

  function automatic logic addr_in_map(int unsigned addr, int unsigned nregs);
    return addr < nregs;
  endfunction

  function automatic logic reg_writable(logic [63:0] ro_mask, int unsigned idx);
    return !ro_mask[idx[5:0]];
  endfunction

endpackage

// File: rtl/bridge_seq.sv
// Request and beat sequencing: latches one request, then steps the address
// once per taken beat until the beat count is used up.
module bridge_seq
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              data_valid_i,
  input  logic              slot_free_i,
  output logic              cmd_accept_o,
  output logic              data_accept_o,
  output logic              beat_fire_o,
  output logic              beat_wr_o,
  output logic [ADDR_W-1:0] beat_addr_o
);

  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              last_beat;

  assign cmd_accept_o  = (phase_q == ST_IDLE) && ((cmd_i == CMD_WR) || (cmd_i == CMD_RD));
  assign data_accept_o = (phase_q == ST_WR) && slot_free_i;
  assign beat_fire_o   = ((phase_q == ST_WR) && data_valid_i && slot_free_i)
                       || ((phase_q == ST_RD) && slot_free_i);
  assign beat_wr_o     = (phase_q == ST_WR);
  assign beat_addr_o   = addr_q;
  assign last_beat     = (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
    end else if (cmd_accept_o) begin
      phase_q <= (cmd_i == CMD_WR) ? ST_WR : ST_RD;
      addr_q  <= addr_i;
      left_q  <= LEN_W'(beat_count(32'(len_i)));
    end else if (beat_fire_o) begin
      addr_q <= addr_q + ADDR_W'(1);
      left_q <= left_q - LEN_W'(1);
      if (last_beat) phase_q <= ST_IDLE;
    end
  end

endmodule

// File: rtl/bridge_bank.sv
// Shared storage: one bus port and one peripheral port; the bus wins a tie.
module bridge_bank #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we_i,
  input  logic [IDX_W-1:0]  bus_idx_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              per_we_i,
  input  logic [IDX_W-1:0]  per_idx_i,
  input  logic [DATA_W-1:0] per_wdata_i,
  input  logic [IDX_W-1:0]  bus_rd_idx_i,
  output logic [DATA_W-1:0] bus_rd_data_o,
  input  logic [IDX_W-1:0]  per_rd_idx_i,
  output logic [DATA_W-1:0] per_rd_data_o,
  output logic              clash_o
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic bus_hit, per_hit;
    assign bus_hit = bus_we_i && (bus_idx_i == IDX_W'(g));
    assign per_hit = per_we_i && (per_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       regs_q[g] <= '0;
      else if (bus_hit) regs_q[g] <= bus_wdata_i;
      else if (per_hit) regs_q[g] <= per_wdata_i;
    end
  end

  assign bus_rd_data_o = regs_q[bus_rd_idx_i];
  assign per_rd_data_o = regs_q[per_rd_idx_i];
  assign clash_o       = bus_we_i && per_we_i && (bus_idx_i == per_idx_i);

endmodule

// File: rtl/bridge_resp.sv
// One-entry response slot: filled by a taken beat, drained by the master.
module bridge_resp
  import bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_fire_i,
  input  logic              beat_wr_i,
  input  logic              beat_ok_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              resp_accept_i,
  output logic              slot_free_o,
  output logic [1:0]        resp_o,
  output logic [DATA_W-1:0] rdata_o
);

  resp_e             resp_q;
  logic [DATA_W-1:0] rdata_q;

  assign slot_free_o = (resp_q == RSP_NULL) || resp_accept_i;
  assign resp_o      = resp_q;
  assign rdata_o     = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q  <= RSP_NULL;
      rdata_q <= '0;
    end else if (beat_fire_i) begin
      resp_q  <= beat_ok_i ? RSP_DVA : RSP_ERR;
      rdata_q <= (beat_ok_i && !beat_wr_i) ? rd_data_i : '0;
    end else if (resp_accept_i) begin
      resp_q  <= RSP_NULL;
      rdata_q <= '0;
    end
  end

endmodule

// File: rtl/bus_reg_bridge.sv
module bus_reg_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 4,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter logic [NUM_REGS-1:0] RO_MASK = NUM_REGS'(16'hF000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        m_cmd,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [LEN_W-1:0]  m_burst_len,
  input  logic              m_data_valid,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              s_cmd_accept,
  output logic              s_data_accept,
  output logic [1:0]        s_resp,
  output logic [DATA_W-1:0] s_rdata,
  input  logic              m_resp_accept,
  input  logic              p_wr_en,
  input  logic [IDX_W-1:0]  p_wr_addr,
  input  logic [DATA_W-1:0] p_wr_data,
  input  logic [IDX_W-1:0]  p_rd_addr,
  output logic [DATA_W-1:0] p_rd_data
);

  // named internal events, observed by the bound checker
  logic              beat_fire;
  logic              beat_wr;
  logic [ADDR_W-1:0] beat_addr;
  logic              slot_free;
  logic              beat_in_map;
  logic              beat_writable;
  logic              beat_ok;
  logic              bus_we;
  logic              bank_clash;
  logic [IDX_W-1:0]  beat_idx;
  logic [DATA_W-1:0] bus_rd_data;

  assign beat_idx      = beat_addr[IDX_W-1:0];
  assign beat_in_map   = addr_in_map(32'(beat_addr), NUM_REGS);
  assign beat_writable = reg_writable(64'(RO_MASK), 32'(beat_idx));
  assign beat_ok       = beat_in_map && (!beat_wr || beat_writable);
  assign bus_we        = beat_fire && beat_wr && beat_ok;

  bridge_seq #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (m_cmd),
    .addr_i       (m_addr),
    .len_i        (m_burst_len),
    .data_valid_i (m_data_valid),
    .slot_free_i  (slot_free),
    .cmd_accept_o (s_cmd_accept),
    .data_accept_o(s_data_accept),
    .beat_fire_o  (beat_fire),
    .beat_wr_o    (beat_wr),
    .beat_addr_o  (beat_addr)
  );

  bridge_bank #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we_i     (bus_we),
    .bus_idx_i    (beat_idx),
    .bus_wdata_i  (m_wdata),
    .per_we_i     (p_wr_en),
    .per_idx_i    (p_wr_addr),
    .per_wdata_i  (p_wr_data),
    .bus_rd_idx_i (beat_idx),
    .bus_rd_data_o(bus_rd_data),
    .per_rd_idx_i (p_rd_addr),
    .per_rd_data_o(p_rd_data),
    .clash_o      (bank_clash)
  );

  bridge_resp #(
    .DATA_W(DATA_W)
  ) u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_fire_i  (beat_fire),
    .beat_wr_i    (beat_wr),
    .beat_ok_i    (beat_ok),
    .rd_data_i    (bus_rd_data),
    .resp_accept_i(m_resp_accept),
    .slot_free_o  (slot_free),
    .resp_o       (s_resp),
    .rdata_o      (s_rdata)
  );

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4,
  parameter logic [NUM_REGS-1:0] RO_MASK = NUM_REGS'(16'hF000)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        m_cmd,
  input logic              m_resp_accept,
  input logic              s_cmd_accept,
  input logic [1:0]        s_resp,
  input logic [DATA_W-1:0] s_rdata,
  input logic              beat_fire,
  input logic              beat_wr,
  input logic [ADDR_W-1:0] beat_addr
);

  logic addr_out, addr_ro, resp_held;
  assign addr_out  = 32'(beat_addr) >= NUM_REGS;
  assign addr_ro   = RO_MASK[beat_addr[IDX_W-1:0]];
  assign resp_held = (s_resp != 2'b00) && !m_resp_accept;

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (s_resp == 2'b00));

  p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_cmd_accept |-> ((m_cmd == 3'b001) || (m_cmd == 3'b010)));

  p_resp_follows_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> ((s_resp == 2'b01) || (s_resp == 2'b11)));

  p_rdata_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_resp != 2'b01) |-> (s_rdata == '0));

  p_out_of_map_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && addr_out) |=> (s_resp == 2'b11));

  p_ro_write_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_wr && !addr_out && addr_ro) |=> (s_resp == 2'b11));

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_held |=> ($stable(s_resp) && $stable(s_rdata)));

  p_no_beat_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_held |-> !beat_fire);

endmodule

bind bus_reg_bridge bridge_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS),
  .IDX_W   (IDX_W),
  .RO_MASK (RO_MASK)
) i_bridge_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .m_cmd        (m_cmd),
  .m_resp_accept(m_resp_accept),
  .s_cmd_accept (s_cmd_accept),
  .s_resp       (s_resp),
  .s_rdata      (s_rdata),
  .beat_fire    (beat_fire),
  .beat_wr      (beat_wr),
  .beat_addr    (beat_addr)
);

// File: tb/test_bus_reg_bridge.sv
`timescale 1ns/1ps
module test_bus_reg_bridge;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] m_cmd = 3'b000;
  logic [7:0] m_addr = '0;
  logic [3:0] m_burst_len = '0;
  logic       m_data_valid = 1'b0;
  logic [7:0] m_wdata = '0;
  logic       s_cmd_accept, s_data_accept;
  logic [1:0] s_resp;
  logic [7:0] s_rdata;
  logic       m_resp_accept = 1'b1;
  logic       p_wr_en = 1'b0;
  logic [3:0] p_wr_addr = '0;
  logic [7:0] p_wr_data = '0;
  logic [3:0] p_rd_addr = '0;
  logic [7:0] p_rd_data;

  int n_checks = 0;
  int n_fail = 0;
  int n_log = 0;
  logic [1:0] log_resp [64];
  logic [7:0] log_data [64];

  always #2.5 clk = ~clk;

  bus_reg_bridge i_bus_reg_bridge (
    .clk(clk), .rst_n(rst_n), .m_cmd(m_cmd), .m_addr(m_addr),
    .m_burst_len(m_burst_len), .m_data_valid(m_data_valid), .m_wdata(m_wdata),
    .s_cmd_accept(s_cmd_accept), .s_data_accept(s_data_accept),
    .s_resp(s_resp), .s_rdata(s_rdata), .m_resp_accept(m_resp_accept),
    .p_wr_en(p_wr_en), .p_wr_addr(p_wr_addr), .p_wr_data(p_wr_data),
    .p_rd_addr(p_rd_addr), .p_rd_data(p_rd_data)
  );

  // response logger: records each response the master takes, late in the cycle
  always @(negedge clk) begin
    #2;
    if (rst_n && s_resp != 2'b00 && m_resp_accept && n_log < 64) begin
      log_resp[n_log] = s_resp;
      log_data[n_log] = s_rdata;
      n_log++;
    end
  end

  // cmd, addr, wdata, expected response, expected read data
  localparam logic [28:0] VEC [11] = '{
    {3'b001, 8'h00, 8'hA5, 2'b01, 8'h00},
    {3'b001, 8'h01, 8'h3C, 2'b01, 8'h00},
    {3'b010, 8'h00, 8'h00, 2'b01, 8'hA5},
    {3'b010, 8'h01, 8'h00, 2'b01, 8'h3C},
    {3'b001, 8'h0C, 8'h77, 2'b11, 8'h00},
    {3'b010, 8'h0C, 8'h00, 2'b01, 8'h00},
    {3'b001, 8'h14, 8'h11, 2'b11, 8'h00},
    {3'b010, 8'h14, 8'h00, 2'b11, 8'h00},
    {3'b001, 8'h0B, 8'h5A, 2'b01, 8'h00},
    {3'b010, 8'h0B, 8'h00, 2'b01, 8'h5A},
    {3'b010, 8'hFF, 8'h00, 2'b11, 8'h00}
  };

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_cmd(input logic [2:0] cmd, input logic [7:0] addr, input logic [3:0] len);
    @(negedge clk);
    m_cmd = cmd; m_addr = addr; m_burst_len = len;
    #1;
    while (!s_cmd_accept) begin @(negedge clk); #1; end
    @(negedge clk);
    m_cmd = 3'b000;
  endtask

  task automatic wr_beats(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      m_wdata = base + 8'(i);
      m_data_valid = 1'b1;
      #1;
      while (!s_data_accept) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    m_data_valid = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [1:0] held_resp;
    logic [7:0] held_data;

    // R1 reset state
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_eq("R1", "s_resp after reset", s_resp, 0);
    check_eq("R1", "s_rdata after reset", s_rdata, 0);
    for (int r = 0; r < 16; r++) begin
      p_rd_addr = 4'(r); #0.1;
      check_eq("R1", "register after reset", p_rd_data, 0);
    end

    // single-beat vectors: R4 R5 R6 R7 R8
    for (int v = 0; v < 11; v++) begin
      n_log = 0;
      start_cmd(VEC[v][28:26], VEC[v][25:18], 4'd1);
      if (VEC[v][28:26] == 3'b001) wr_beats(1, VEC[v][17:10]);
      wait_cycles(3);
      check_eq("R5", "vector response count", n_log, 1);
      check_eq("R5 R7 R8", "vector response code", log_resp[0], VEC[v][9:8]);
      check_eq("R4 R6", "vector read data", log_data[0], VEC[v][7:0]);
    end
    p_rd_addr = 4'd12; #0.1;
    check_eq("R8", "read-only register after bus write", p_rd_data, 0);

    // R3 burst write of 4 beats from address 4, then read back as a burst
    n_log = 0;
    start_cmd(3'b001, 8'h04, 4'd4);
    wr_beats(4, 8'h40);
    wait_cycles(3);
    check_eq("R3", "write burst response count", n_log, 4);
    n_log = 0;
    start_cmd(3'b010, 8'h04, 4'd4);
    wait_cycles(7);
    check_eq("R3", "read burst response count", n_log, 4);
    for (int i = 0; i < 4; i++) begin
      check_eq("R3", "read burst code", log_resp[i], 1);
      check_eq("R3", "read burst data", log_data[i], 8'h40 + i);
    end

    // R3 R8 burst running into the read-only area: 10,11 DVA, 12 ERR
    n_log = 0;
    start_cmd(3'b001, 8'h0A, 4'd3);
    wr_beats(3, 8'h60);
    wait_cycles(3);
    check_eq("R8", "crossing burst count", n_log, 3);
    check_eq("R8", "crossing beat 10", log_resp[0], 1);
    check_eq("R8", "crossing beat 11", log_resp[1], 1);
    check_eq("R8", "crossing beat 12", log_resp[2], 3);
    p_rd_addr = 4'd11; #0.1;
    check_eq("R3", "register 11 from burst", p_rd_data, 8'h61);
    p_rd_addr = 4'd12; #0.1;
    check_eq("R8", "register 12 untouched", p_rd_data, 0);

    // R3 zero length means one beat
    n_log = 0;
    start_cmd(3'b010, 8'h05, 4'd0);
    wait_cycles(5);
    check_eq("R3", "zero length response count", n_log, 1);
    check_eq("R3", "zero length data", log_data[0], 8'h41);

    // R2 unknown command and IDLE are ignored
    n_log = 0;
    @(negedge clk);
    m_cmd = 3'b011; #1;
    check_eq("R2", "unknown command accept", s_cmd_accept, 0);
    wait_cycles(3);
    m_cmd = 3'b000; #1;
    check_eq("R2", "idle accept", s_cmd_accept, 0);
    wait_cycles(2);
    check_eq("R2", "responses after unknown command", n_log, 0);
    check_eq("R2", "s_resp after unknown command", s_resp, 0);

    // R10 peripheral writes a status register; master polls it
    @(negedge clk);
    p_wr_en = 1'b1; p_wr_addr = 4'd13; p_wr_data = 8'h9E;
    @(negedge clk);
    p_wr_en = 1'b0;
    p_rd_addr = 4'd13; #0.1;
    check_eq("R10", "peripheral read port", p_rd_data, 8'h9E);
    n_log = 0;
    start_cmd(3'b010, 8'h0D, 4'd1);
    wait_cycles(3);
    check_eq("R10", "polled status code", log_resp[0], 1);
    check_eq("R10", "polled status data", log_data[0], 8'h9E);

    // R9 back-pressure: response held until accepted, no second beat meanwhile
    m_resp_accept = 1'b0;
    n_log = 0;
    start_cmd(3'b010, 8'h00, 4'd2);
    wait_cycles(2);
    #1;
    held_resp = s_resp;
    held_data = s_rdata;
    check_eq("R9", "held response code", held_resp, 1);
    check_eq("R9", "held response data", held_data, 8'hA5);
    wait_cycles(4);
    #1;
    check_eq("R9", "code still held", s_resp, held_resp);
    check_eq("R9", "data still held", s_rdata, held_data);
    m_resp_accept = 1'b1;
    wait_cycles(4);
    check_eq("R9", "responses after release", n_log, 2);
    check_eq("R9", "second beat data", log_data[1], 8'h3C);

    // R11 bus write and peripheral write to the same register, same edge
    n_log = 0;
    start_cmd(3'b001, 8'h02, 4'd1);
    m_wdata = 8'hB1; m_data_valid = 1'b1;
    p_wr_en = 1'b1; p_wr_addr = 4'd2; p_wr_data = 8'hC2;
    #1;
    check_eq("R11", "beat ready in clash cycle", s_data_accept, 1);
    @(negedge clk);
    m_data_valid = 1'b0; p_wr_en = 1'b0;
    p_rd_addr = 4'd2; #0.1;
    check_eq("R11", "same register keeps bus data", p_rd_data, 8'hB1);

    // R11 different registers in the same cycle: both land
    start_cmd(3'b001, 8'h02, 4'd1);
    m_wdata = 8'hD4; m_data_valid = 1'b1;
    p_wr_en = 1'b1; p_wr_addr = 4'd3; p_wr_data = 8'hE5;
    #1;
    check_eq("R11", "beat ready in split cycle", s_data_accept, 1);
    @(negedge clk);
    m_data_valid = 1'b0; p_wr_en = 1'b0;
    p_rd_addr = 4'd2; #0.1;
    check_eq("R11", "bus register in split cycle", p_rd_data, 8'hD4);
    p_rd_addr = 4'd3; #0.1;
    check_eq("R11", "peripheral register in split cycle", p_rd_data, 8'hE5);
    wait_cycles(3);

    summary();
    $finish;
  end

endmodule